// File: doc/BRIEF.md
# Parallel I/O Bus Cycle Sequencer

This block is a bus master for a simple parallel I/O backplane. The backplane carries eight bidirectional data lines, four address lines, a chip select, and separate read and write strobes. A command port takes a direction, an address, write data and a per-bit input mask. The block then runs one complete bus cycle, in which each step is a timed phase. It returns read data together with a one-cycle completion pulse.

Phase lengths are parameters counted in clock cycles:

- the setup gaps;
- the minimum write strobe width;
- the delay from read strobe assertion to data sampling;
- the hold gap.

A polarity parameter selects an active-low backplane or an active-high backplane. Any data bit marked as an input stays released for the whole cycle, so an external module can drive that bit while the other bits are written.

States:

- `ST_IDLE` accepts a command.
- A write runs `ST_W_ADDR` (address and select shown, data value shown, drivers off), `ST_W_DRIVE` (drivers on), `ST_W_STROBE` (write strobe), `ST_W_HOLD` (strobe off, data and address kept), `ST_W_UNADDR` (address and select idle, data still driven) and then `ST_FINISH`.
- A read runs `ST_R_ADDR`, `ST_R_STROBE` (sampled in its last cycle), `ST_R_HOLD` and then `ST_FINISH`.
- `ST_FINISH` releases everything, pulses done and returns to `ST_IDLE`.

Each timed state moves on when its phase counter expires. The length of each state is:

| State | Length in cycles |
|---|---|
| `ST_W_ADDR`, `ST_W_DRIVE`, `ST_R_ADDR` | `SETUP_CYC` |
| `ST_W_STROBE` | `STROBE_CYC` |
| `ST_R_STROBE` | `SAMPLE_CYC` |
| `ST_W_HOLD`, `ST_R_HOLD` | `HOLD_CYC` |
| `ST_W_UNADDR`, `ST_FINISH` | 1 |

Top module: `pbus_cycle_master`

## Requirements
- R1: After reset both strobes and the select are at their idle level, all data enables are 0, the address lines carry logical 0 at the physical level, busy and done are 0, and the read data output is 0.
- R2: A write shows address and select for `SETUP_CYC` cycles with all data enables off. It then turns the data enables on for `SETUP_CYC` cycles before the write strobe asserts.
- R3: The write strobe stays asserted for exactly `STROBE_CYC` cycles. During that time the address, the select and the data enables are held, and every driven bit carries the command's data.
- R4: After the write strobe drops, the data stays driven with the address held for `HOLD_CYC` cycles. The address and select then go idle for one cycle with the data still driven, and only after that are the drivers released.
- R5: A read shows address and select for `SETUP_CYC` cycles, then holds the read strobe for `SAMPLE_CYC` cycles. The data lines are sampled in the last strobe cycle. Address and select then stay for `HOLD_CYC` cycles after the strobe drops. No data enable is on during a read.
- R6: The read data output changes only when a read samples. It holds its value across writes and idle time.
- R7: A data bit whose input-mask bit is 1 has its enable at 0 for the whole write, while the unmasked bits are driven.
- R8: With `ACTIVE_LOW`=1, the select and the strobes assert at 0, and the address and data lines carry the complement of the logical values. With `ACTIVE_LOW`=0, all of these lines carry the true values and assert at 1. Read data is decoded with the same rule.
- R9: Busy is high from the cycle after a command is accepted through the done cycle. A write is busy for 2·`SETUP_CYC`+`STROBE_CYC`+`HOLD_CYC`+2 cycles, and a read for `SETUP_CYC`+`SAMPLE_CYC`+`HOLD_CYC`+1 cycles. Done lasts one cycle and is followed by busy low. A command that is valid while busy is ignored.
- R10: The read and write strobes are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_addr | input | 4 | Logical backplane address |
| cmd_wdata | input | 8 | Logical write data |
| cmd_inmask | input | 8 | 1 = bit is an input, kept released during a write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Logical data from the last read |
| bus_addr | output | 4 | Address lines, physical level |
| bus_sel | output | 1 | Chip select, physical level |
| bus_rd | output | 1 | Read strobe, physical level |
| bus_wr | output | 1 | Write strobe, physical level |
| bus_d_out | output | 8 | Data line drive values, physical level |
| bus_d_oe | output | 8 | Per-bit data driver enable |
| bus_d_in | input | 8 | Data line levels as seen on the backplane |

## Verification
The bench builds two copies side by side from the same commands, one with `ACTIVE_LOW`=1 and one with `ACTIVE_LOW`=0. The second copy's data inputs are the complement of the first copy's, so every physical output must mirror the first copy bit for bit. Short phases (setup 2, strobe 4, sample 3, hold 2) keep whole cycles at a dozen clocks. This allows the bench to count each phase exactly and to overlap illegal requests with running cycles. The device model presents valid read data only in the final strobe cycle, so any early or late sample produces a wrong value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_ADDR,
        ST_W_DRIVE,
        ST_W_STROBE,
        ST_W_HOLD,
        ST_W_UNADDR,
        ST_R_ADDR,
        ST_R_STROBE,
        ST_R_HOLD,
        ST_FINISH
    } pbus_state_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pbus_seq_fsm.sv
module pbus_seq_fsm
    import pbus_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned STROBE_CYC = 200,
    parameter int unsigned SAMPLE_CYC = 200,
    parameter int unsigned HOLD_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] cmd_inmask,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              addr_act,
    output logic              data_vis,
    output logic              drive_en,
    output logic              wr_act,
    output logic              rd_act,
    output logic              capture,
    output logic              busy,
    output logic              done
);

    localparam int unsigned MAX_LEN =
        max2(max2(SETUP_CYC, HOLD_CYC), max2(STROBE_CYC, SAMPLE_CYC));
    localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

    pbus_state_t state_q, state_d;
    logic             expired;
    logic             load;
    logic [CNT_W-1:0] load_val;

    function automatic logic [CNT_W-1:0] phase_len(input pbus_state_t s);
        unique case (s)
            ST_W_ADDR, ST_W_DRIVE, ST_R_ADDR: return CNT_W'(SETUP_CYC - 1);
            ST_W_STROBE:                      return CNT_W'(STROBE_CYC - 1);
            ST_R_STROBE:                      return CNT_W'(SAMPLE_CYC - 1);
            ST_W_HOLD, ST_R_HOLD:             return CNT_W'(HOLD_CYC - 1);
            default:                          return '0;
        endcase
    endfunction

    pbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid) state_d = cmd_write ? ST_W_ADDR : ST_R_ADDR;
            ST_W_ADDR:   if (expired) state_d = ST_W_DRIVE;
            ST_W_DRIVE:  if (expired) state_d = ST_W_STROBE;
            ST_W_STROBE: if (expired) state_d = ST_W_HOLD;
            ST_W_HOLD:   if (expired) state_d = ST_W_UNADDR;
            ST_W_UNADDR: state_d = ST_FINISH;
            ST_R_ADDR:   if (expired) state_d = ST_R_STROBE;
            ST_R_STROBE: if (expired) state_d = ST_R_HOLD;
            ST_R_HOLD:   if (expired) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign load     = (state_d != state_q);
    assign load_val = phase_len(state_d);

    // state register and command latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                addr_q  <= cmd_addr;
                wdata_q <= cmd_wdata;
                mask_q  <= cmd_inmask;
            end
        end
    end

    // per-state outputs
    always_comb begin
        addr_act = 1'b0;
        data_vis = 1'b0;
        drive_en = 1'b0;
        wr_act   = 1'b0;
        rd_act   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_W_ADDR:   begin addr_act = 1'b1; data_vis = 1'b1; end
            ST_W_DRIVE:  begin addr_act = 1'b1; data_vis = 1'b1; drive_en = 1'b1; end
            ST_W_STROBE: begin addr_act = 1'b1; data_vis = 1'b1; drive_en = 1'b1; wr_act = 1'b1; end
            ST_W_HOLD:   begin addr_act = 1'b1; data_vis = 1'b1; drive_en = 1'b1; end
            ST_W_UNADDR: begin data_vis = 1'b1; drive_en = 1'b1; end
            ST_R_ADDR:   addr_act = 1'b1;
            ST_R_STROBE: begin addr_act = 1'b1; rd_act = 1'b1; end
            ST_R_HOLD:   addr_act = 1'b1;
            ST_FINISH:   done = 1'b1;
            default:     ;
        endcase
    end

    assign capture = (state_q == ST_R_STROBE) && expired;
    assign busy    = (state_q != ST_IDLE);

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_act && rd_act));
    a_r3_strobe_context: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |-> (drive_en && addr_act));
    a_r2_drive_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_act) |-> $past(drive_en));
    a_r4_unaddr_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> (!addr_act && $past(!addr_act)));
    a_r5_sample_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (rd_act && addr_act));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/pbus_line_map.sv
module pbus_line_map #(
    parameter bit          ACTIVE_LOW = 1'b1,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] mask_q,
    input  logic              addr_act,
    input  logic              data_vis,
    input  logic              drive_en,
    input  logic              wr_act,
    input  logic              rd_act,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_sel,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_d_out,
    output logic [DATA_W-1:0] bus_d_oe,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic FLIP = ACTIVE_LOW;

    logic [ADDR_W-1:0] addr_log;
    logic [DATA_W-1:0] data_log;
    logic [DATA_W-1:0] rd_q;

    assign addr_log = addr_act ? addr_q : '0;
    assign data_log = data_vis ? wdata_q : '0;

    assign bus_addr = addr_log ^ {ADDR_W{FLIP}};
    assign bus_sel  = addr_act ^ FLIP;
    assign bus_rd   = rd_act ^ FLIP;
    assign bus_wr   = wr_act ^ FLIP;

    // per-bit drive: masked bits stay released
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign bus_d_out[b] = data_log[b] ^ FLIP;
        assign bus_d_oe[b]  = drive_en & ~mask_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (capture) begin
            rd_q <= bus_d_in ^ {DATA_W{FLIP}};
        end
    end

    assign rd_data = rd_q;

    a_r7_masked_bits_released: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_d_oe & mask_q) == '0);

endmodule

// File: rtl/pbus_cycle_master.sv
module pbus_cycle_master #(
    parameter bit          ACTIVE_LOW = 1'b1,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned STROBE_CYC = 200,
    parameter int unsigned SAMPLE_CYC = 200,
    parameter int unsigned HOLD_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] cmd_inmask,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_sel,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_d_out,
    output logic [DATA_W-1:0] bus_d_oe,
    input  logic [DATA_W-1:0] bus_d_in
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] mask_q;
    logic addr_act, data_vis, drive_en, wr_act, rd_act, capture;

    pbus_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .SAMPLE_CYC(SAMPLE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_inmask(cmd_inmask),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .mask_q    (mask_q),
        .addr_act  (addr_act),
        .data_vis  (data_vis),
        .drive_en  (drive_en),
        .wr_act    (wr_act),
        .rd_act    (rd_act),
        .capture   (capture),
        .busy      (busy),
        .done      (done)
    );

    pbus_line_map #(
        .ACTIVE_LOW(ACTIVE_LOW),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .mask_q   (mask_q),
        .addr_act (addr_act),
        .data_vis (data_vis),
        .drive_en (drive_en),
        .wr_act   (wr_act),
        .rd_act   (rd_act),
        .capture  (capture),
        .bus_d_in (bus_d_in),
        .bus_addr (bus_addr),
        .bus_sel  (bus_sel),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_d_out(bus_d_out),
        .bus_d_oe (bus_d_oe),
        .rd_data  (rd_data)
    );

    a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(capture));
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_d_oe == '0));

endmodule

// File: tb/test_pbus_cycle_master.sv
module test_pbus_cycle_master;

    localparam int SETUP  = 2;
    localparam int STROBE = 4;
    localparam int SAMPLE = 3;
    localparam int HOLD   = 2;
    localparam int W_TOTAL = 2*SETUP + STROBE + HOLD + 2;
    localparam int R_TOTAL = SETUP + SAMPLE + HOLD + 1;

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] data;
        logic [7:0] mask;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [3:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0, cmd_inmask = '0;

    logic busy, done, busy_h, done_h;
    logic [7:0] rd_data, rd_data_h;
    logic [3:0] bus_addr, bus_addr_h;
    logic bus_sel, bus_rd, bus_wr, bus_sel_h, bus_rd_h, bus_wr_h;
    logic [7:0] d_out, d_oe, d_in, d_out_h, d_oe_h, d_in_h;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pbus_cycle_master #(.ACTIVE_LOW(1'b1), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE),
                        .SAMPLE_CYC(SAMPLE), .HOLD_CYC(HOLD)) i_pbus_cycle_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_inmask(cmd_inmask),
        .busy(busy), .done(done), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_d_out(d_out), .bus_d_oe(d_oe), .bus_d_in(d_in));

    pbus_cycle_master #(.ACTIVE_LOW(1'b0), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE),
                        .SAMPLE_CYC(SAMPLE), .HOLD_CYC(HOLD)) i_pbus_cycle_master_hi (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_inmask(cmd_inmask),
        .busy(busy_h), .done(done_h), .rd_data(rd_data_h), .bus_addr(bus_addr_h),
        .bus_sel(bus_sel_h), .bus_rd(bus_rd_h), .bus_wr(bus_wr_h),
        .bus_d_out(d_out_h), .bus_d_oe(d_oe_h), .bus_d_in(d_in_h));

    function automatic logic [7:0] dev_val(input logic [3:0] a);
        return 8'hA5 ^ {a, ~a};
    endfunction

    // device model (logical view of the active-low copy)
    logic       l_sel, l_rd, l_wr;
    logic [3:0] l_addr;
    logic [7:0] l_dout, ext_log;
    int         tcnt = 0;

    assign l_sel  = ~bus_sel;
    assign l_rd   = ~bus_rd;
    assign l_wr   = ~bus_wr;
    assign l_addr = ~bus_addr;
    assign l_dout = ~d_out;
    assign ext_log = (l_rd && l_sel && tcnt == SAMPLE-1) ? dev_val(l_addr) : ~dev_val(l_addr);

    for (genvar b = 0; b < 8; b++) begin : g_line
        assign d_in[b] = d_oe[b] ? d_out[b] : ~ext_log[b];
    end
    assign d_in_h = ~d_in;

    always @(posedge clk) tcnt <= l_rd ? tcnt + 1 : 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // scoreboard
    item_t exp_q[$];
    logic [7:0] last_rd = '0;
    int n_busy, n_pre_addr, n_pre_drive, n_wr, n_rd, n_post, n_unaddr;
    bit seen_strobe, bad_addr, bad_wr_ctx, bad_data, bad_mask, bad_rd_oe, bad_both, post_done;
    int mirror_bad = 0;

    task automatic clear_obs();
        n_busy = 0; n_pre_addr = 0; n_pre_drive = 0; n_wr = 0; n_rd = 0;
        n_post = 0; n_unaddr = 0; seen_strobe = 0; bad_addr = 0; bad_wr_ctx = 0;
        bad_data = 0; bad_mask = 0; bad_rd_oe = 0; bad_both = 0;
    endtask

    initial clear_obs();
    initial post_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R8: the active-high copy mirrors the active-low copy
            if (bus_addr_h != ~bus_addr || bus_sel_h != ~bus_sel || bus_rd_h != ~bus_rd ||
                bus_wr_h != ~bus_wr || d_out_h != ~d_out || d_oe_h != d_oe ||
                rd_data_h != rd_data || busy_h != busy || done_h != done)
                mirror_bad++;

            if (post_done) begin
                chk(!busy && !done, "R9 busy/done low after done", {busy, done}, 0);
                post_done = 0;
            end

            if (busy) begin
                n_busy++;
                if (exp_q.size() == 0) begin
                    chk(0, "R9 cycle without accepted command", 1, 0);
                end else begin
                    if (l_sel && l_addr != exp_q[0].addr) bad_addr = 1;
                    if ((d_oe & exp_q[0].mask) != 0) bad_mask = 1;
                    if (!exp_q[0].wr && d_oe != 0) bad_rd_oe = 1;
                    if (l_wr && l_rd) bad_both = 1;
                    if (l_wr) begin
                        n_wr++; seen_strobe = 1;
                        if (!l_sel || d_oe != ~exp_q[0].mask) bad_wr_ctx = 1;
                        if ((l_dout & d_oe) != (exp_q[0].data & d_oe)) bad_data = 1;
                    end
                    if (l_rd) begin
                        n_rd++; seen_strobe = 1;
                        if (!l_sel) bad_wr_ctx = 1;
                    end
                    if (!l_wr && !l_rd) begin
                        if (l_sel && d_oe == 0 && !seen_strobe) n_pre_addr++;
                        if (l_sel && d_oe != 0 && !seen_strobe) n_pre_drive++;
                        if (l_sel && seen_strobe) n_post++;
                        if (!l_sel && d_oe != 0) n_unaddr++;
                    end
                end
            end

            if (done && exp_q.size() != 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(!bad_addr, "R8 logical address on lines", {28'd0, it.addr}, {28'd0, it.addr});
                chk(!bad_both, "R10 strobes together", 1, 0);
                if (it.wr) begin
                    chk(n_pre_addr == SETUP, "R2 address-only phase", n_pre_addr, SETUP);
                    chk(n_pre_drive == SETUP, "R2 drive-before-strobe phase", n_pre_drive, SETUP);
                    chk(n_wr == STROBE, "R3 write strobe width", n_wr, STROBE);
                    chk(!bad_wr_ctx && !bad_data, "R3 strobe context and data", {bad_wr_ctx, bad_data}, 0);
                    chk(n_post == HOLD, "R4 data hold phase", n_post, HOLD);
                    chk(n_unaddr == 1, "R4 unaddressed drive phase", n_unaddr, 1);
                    chk(!bad_mask, "R7 masked bits released", bad_mask, 0);
                    chk(n_busy == W_TOTAL, "R9 write busy length", n_busy, W_TOTAL);
                    chk(rd_data == last_rd, "R6 read data held over write", rd_data, last_rd);
                end else begin
                    chk(n_pre_addr == SETUP, "R5 read setup", n_pre_addr, SETUP);
                    chk(n_rd == SAMPLE, "R5 read strobe width", n_rd, SAMPLE);
                    chk(n_post == HOLD, "R5 read hold", n_post, HOLD);
                    chk(!bad_rd_oe && !bad_wr_ctx, "R5 no drive during read", d_oe, 0);
                    chk(rd_data == dev_val(it.addr), "R5 sampled data", rd_data, dev_val(it.addr));
                    chk(n_busy == R_TOTAL, "R9 read busy length", n_busy, R_TOTAL);
                    last_rd = dev_val(it.addr);
                end
                clear_obs();
                post_done = 1;
            end
        end
    end

    task automatic do_cmd(input bit wr, input logic [3:0] a, input logic [7:0] d,
                          input logic [7:0] m, input bit poke);
        item_t it;
        while (busy) @(negedge clk);
        it = '{wr: wr, addr: a, data: d, mask: m};
        exp_q.push_back(it);
        cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_inmask = m; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            // R9: request while busy must be ignored
            cmd_write = ~wr; cmd_addr = ~a; cmd_wdata = ~d; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset levels for both polarities
        chk(bus_rd && bus_wr && bus_sel, "R1 low-active strobes idle", {bus_rd, bus_wr, bus_sel}, 3'b111);
        chk(bus_addr == 4'hF, "R1 address idle level", bus_addr, 4'hF);
        chk(d_oe == 0 && !busy && !done, "R1 drivers released, not busy", {d_oe, busy, done}, 0);
        chk(rd_data == 0, "R1 read data cleared", rd_data, 0);
        chk(!bus_rd_h && !bus_wr_h && !bus_sel_h && bus_addr_h == 0,
            "R8 high-active idle levels", {bus_rd_h, bus_wr_h, bus_sel_h, bus_addr_h}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_cmd(1'b0, 4'h0, 8'h00, 8'h00, 1'b0);
        do_cmd(1'b1, 4'h3, 8'h5A, 8'h00, 1'b0);
        do_cmd(1'b0, 4'hF, 8'h00, 8'h00, 1'b0);
        do_cmd(1'b1, 4'hC, 8'hFF, 8'hF0, 1'b0);
        do_cmd(1'b1, 4'h9, 8'h3C, 8'h81, 1'b1);
        do_cmd(1'b0, 4'h5, 8'h00, 8'h00, 1'b1);
        do_cmd(1'b1, 4'h0, 8'h00, 8'h00, 1'b0);
        do_cmd(1'b0, 4'hA, 8'h00, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        chk(rd_data == dev_val(4'hA), "R6 read data held while idle", rd_data, dev_val(4'hA));
        chk(mirror_bad == 0, "R8 polarity mirror mismatches", mirror_bad, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule